// File: doc/BRIEF.md
# Single-Precision Float to Signed 32-bit Integer Converter

This unit takes a 32-bit single-precision floating-point operand and produces the signed 32-bit integer it rounds to, under a rounding mode chosen per operation by a 3-bit code. Operands that have no representable integer result yield a saturated value, and the unit raises an invalid flag for them. An inexact flag reports that fraction bits were discarded. The inexact flag never appears together with the invalid flag.

The converter is a two-stage pipeline. It accepts one operand per cycle and has a fixed latency. The first stage aligns the significand to the integer binary point. Every bit shifted out on the right is kept, either as the guard bit or folded into a sticky bit. The second stage applies the rounding increment, checks the range, negates and saturates. A rounding code that is not defined gives an error indication and a zero result.

Top module: `fp32_to_int32`

## Requirements
- R1: A result appears on the output with `out_valid` high exactly two clock cycles after the operand is presented with `in_valid` high. `out_valid` is low in every other cycle.
- R2: An operand whose value is an integer within range converts exactly, with both flags low.
- R3: Rounding follows `in_rm`: 000 is nearest with ties to even, 001 is toward zero, 010 is toward negative infinity, 011 is toward positive infinity, and 100 is nearest with ties away from zero.
- R4: `out_nx` is high when the operand had a nonzero fraction and `out_nv` is low. `out_nx` and `out_nv` are never high together.
- R5: Negative infinity, and a negative value whose rounded magnitude exceeds 2^31, give 0x80000000 with `out_nv` high.
- R6: Positive infinity, any NaN of either sign, and a positive value that rounds above 2^31-1 give 0x7FFFFFFF with `out_nv` high.
- R7: An operand equal to -2^31 (0xCF000000) gives 0x80000000 with `out_nv` low.
- R8: A zero or subnormal operand gives 0. Under directed rounding away from zero it gives +1 or -1 (0xFFFFFFFF) instead. `out_nx` is high exactly when the operand is nonzero. Negative zero gives 0 with no flags.
- R9: The rounding codes 101, 110 and 111 set `out_rm_err`, and the result is 0 with both flags low.
- R10: While reset is held, `out_valid`, `out_int`, the flags and `out_rm_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_rm | input | 3 | Rounding-mode code |
| out_valid | output | 1 | Result strobe |
| out_int | output | 32 | Signed integer result |
| out_nv | output | 1 | Invalid flag |
| out_nx | output | 1 | Inexact flag |
| out_rm_err | output | 1 | Undefined rounding code |

## Verification
The bench drives small values with exact halves, such as ±0.5, ±1.5 and ±2.5, under each of the five rounding codes. Each rounding mode makes a different choice on these values, and ties-to-even is separated from ties-away. Boundary operands cover the edges of the range: 0x4EFFFFFF, -2^31 exactly, the neighbours of -2^31, infinities, both NaN kinds, and very large exponents. These separate correct saturation from wrap-around and check that -2^31 is accepted without the invalid flag. Subnormals and signed zeros under directed rounding check the path for far right shifts and the sticky bit. Random operands, in a band of exponents near the integer range and also across the full encoding space, are compared every cycle against an arithmetic model that works on quotient and remainder.

// File: rtl/fp32_to_int32.sv
module fp32_to_int32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_op,
  input  logic [2:0]  in_rm,
  output logic        out_valid,
  output logic [31:0] out_int,
  output logic        out_nv,
  output logic        out_nx,
  output logic        out_rm_err
);

  localparam logic [7:0]  BIAS_INT = 8'd150;
  localparam logic [7:0]  EXP_HUGE = 8'd159;
  localparam logic [7:0]  FAR_SH   = 8'd26;
  localparam logic [33:0] POS_LIM  = 34'h0_7FFF_FFFF;
  localparam logic [33:0] NEG_LIM  = 34'h0_8000_0000;
  localparam logic [31:0] SAT_POS  = 32'h7FFF_FFFF;
  localparam logic [31:0] SAT_NEG  = 32'h8000_0000;

  localparam logic [2:0] RM_NE = 3'd0;
  localparam logic [2:0] RM_TZ = 3'd1;
  localparam logic [2:0] RM_DN = 3'd2;
  localparam logic [2:0] RM_UP = 3'd3;
  localparam logic [2:0] RM_MM = 3'd4;

  // stage 1: decode and align
  wire        a_sgn  = in_op[31];
  wire [7:0]  a_exp  = in_op[30:23];
  wire [22:0] a_frac = in_op[22:0];
  wire        a_spec = &a_exp;
  wire [23:0] a_man  = {|a_exp, a_frac};
  wire [7:0]  a_uexp = (a_exp == 8'd0) ? 8'd1 : a_exp;
  wire        a_left = a_uexp >= BIAS_INT;
  wire        a_huge = a_uexp >= EXP_HUGE;
  wire [3:0]  a_lsh  = a_uexp[3:0] - 4'd6;
  wire [7:0]  a_rsh  = BIAS_INT - a_uexp;
  wire [63:0] a_wide = {a_man, 40'd0} >> a_rsh;

  logic [32:0] a_mag;
  logic        a_g, a_s;

  always_comb begin
    if (a_left) begin
      a_mag = {9'd0, a_man} << a_lsh;
      a_g   = 1'b0;
      a_s   = 1'b0;
    end else if (a_rsh >= FAR_SH) begin
      a_mag = '0;
      a_g   = 1'b0;
      a_s   = |a_man;
    end else begin
      a_mag = {9'd0, a_wide[63:40]};
      a_g   = a_wide[39];
      a_s   = |a_wide[38:0];
    end
  end

  logic        v1, sgn1, nan1, inf1, huge1, g1, s1, err1;
  logic [2:0]  rm1;
  logic [32:0] mag1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; sgn1 <= 1'b0; nan1 <= 1'b0; inf1 <= 1'b0; huge1 <= 1'b0;
      g1 <= 1'b0; s1 <= 1'b0; err1 <= 1'b0; rm1 <= '0; mag1 <= '0;
    end else begin
      v1    <= in_valid;
      sgn1  <= a_sgn;
      nan1  <= a_spec & (|a_frac);
      inf1  <= a_spec & ~(|a_frac);
      huge1 <= a_huge & ~a_spec;
      g1    <= a_g;
      s1    <= a_s;
      err1  <= in_rm > RM_MM;
      rm1   <= in_rm;
      mag1  <= a_mag;
    end
  end

  // stage 2: round, range check, negate
  logic inc;
  always_comb begin
    case (rm1)
      RM_NE:   inc = g1 & (s1 | mag1[0]);
      RM_TZ:   inc = 1'b0;
      RM_DN:   inc = sgn1 & (g1 | s1);
      RM_UP:   inc = ~sgn1 & (g1 | s1);
      RM_MM:   inc = g1;
      default: inc = 1'b0;
    endcase
  end

  wire [33:0] rmag   = {1'b0, mag1} + {33'd0, inc};
  wire        oor    = sgn1 ? (rmag > NEG_LIM) : (rmag > POS_LIM);
  wire        bad    = nan1 | inf1 | huge1 | oor;
  wire [31:0] satval = (nan1 | ~sgn1) ? SAT_POS : SAT_NEG;
  wire [31:0] signed_val = sgn1 ? (~rmag[31:0] + 32'd1) : rmag[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_int <= '0; out_nv <= 1'b0; out_nx <= 1'b0; out_rm_err <= 1'b0;
    end else begin
      out_valid  <= v1;
      out_rm_err <= v1 & err1;
      if (!v1 || err1) begin
        out_int <= '0; out_nv <= 1'b0; out_nx <= 1'b0;
      end else if (bad) begin
        out_int <= satval; out_nv <= 1'b1; out_nx <= 1'b0;
      end else begin
        out_int <= signed_val; out_nv <= 1'b0; out_nx <= g1 | s1;
      end
    end
  end

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_nv && out_nx));

  assert_sat_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_nv |-> (out_int == SAT_POS || out_int == SAT_NEG));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_rm_err |-> (out_valid && out_int == 32'd0 && !out_nv && !out_nx));

  assert_sign_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nv && !out_rm_err && out_int != 32'd0) |-> out_int[31] == $past(sgn1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_int == 32'd0 && !out_nv && !out_nx && !out_rm_err));

endmodule

// File: tb/sim_fp32_to_int32.sv
`timescale 1ns/1ps
module sim_fp32_to_int32;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic [2:0]  in_rm = '0;
  logic out_valid, out_nv, out_nx, out_rm_err;
  logic [31:0] out_int;

  fp32_to_int32 u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rm(in_rm),
    .out_valid(out_valid), .out_int(out_int), .out_nv(out_nv), .out_nx(out_nx), .out_rm_err(out_rm_err));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic v; logic [31:0] r; logic nv; logic nx; logic er; logic [31:0] op;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic exp_t model(input logic v, input logic [31:0] x, input logic [2:0] rm);
    exp_t e;
    logic s; int ex; longint m, ue, qv, rem, half, lim;
    bit gt, eq, nz, big, up;
    e = '0; e.v = v; e.op = x;
    if (!v) return e;
    if (rm > 3'd4) begin e.er = 1; return e; end
    s = x[31]; ex = int'(x[30:23]);
    if (ex == 255) begin
      e.nv = 1; e.r = (x[22:0] != 0 || !s) ? 32'h7FFFFFFF : 32'h80000000; return e;
    end
    m  = (ex != 0) ? (longint'(x[22:0]) + 64'sd8388608) : longint'(x[22:0]);
    ue = (ex != 0) ? longint'(ex) : 64'sd1;
    big = 0; gt = 0; eq = 0; nz = 0; qv = 0;
    if (ue >= 150) begin
      if (ue - 150 >= 40) big = 1; else qv = m << (ue - 150);
    end else if (150 - ue >= 62) begin
      nz = (m != 0);
    end else begin
      qv = m >> (150 - ue);
      rem = m - (qv << (150 - ue));
      half = 64'sd1 << (150 - ue - 1);
      gt = rem > half; eq = rem == half; nz = rem != 0;
    end
    case (rm)
      3'd0: up = gt || (eq && qv[0]);
      3'd1: up = 0;
      3'd2: up = s && nz;
      3'd3: up = !s && nz;
      default: up = gt || eq;
    endcase
    qv = qv + (up ? 1 : 0);
    lim = s ? 64'sd2147483648 : 64'sd2147483647;
    if (big || qv > lim) begin
      e.nv = 1; e.r = s ? 32'h80000000 : 32'h7FFFFFFF;
    end else begin
      e.r = s ? 32'(-qv) : 32'(qv);
      e.nx = nz;
    end
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.er) return "R9";
    if (e.op == 32'hCF000000) return "R7";
    if (e.nv) return e.op[31] && !(e.op[30:23] == 8'hFF && e.op[22:0] != 0) ? "R5" : "R6";
    if (e.op[30:23] == 8'd0) return "R8";
    if (e.nx) return "R3";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) if (!finished) q.push_back(model(in_valid, in_op, in_rm));

  always @(negedge clk) begin
    if (rst_n && !finished && q.size() >= 2) begin
      exp_t e;
      e = q[q.size()-2];
      chk(out_valid == e.v, "R1", "valid", 32'(out_valid), 32'(e.v));
      if (e.v) begin
        chk(out_int == e.r, tag_of(e), "int", out_int, e.r);
        chk(out_nv == e.nv, tag_of(e), "nv", 32'(out_nv), 32'(e.nv));
        chk(out_nx == e.nx, "R4", "nx", 32'(out_nx), 32'(e.nx));
        chk(out_rm_err == e.er, "R9", "rm_err", 32'(out_rm_err), 32'(e.er));
      end
      while (q.size() > 2) void'(q.pop_front());
    end
  end

  task automatic drive(input logic [31:0] op, input logic [2:0] rm);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rm = rm;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_op = $urandom; in_rm = 3'($urandom);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    total++; bad++;
    $display("FAIL watchdog run did not complete actual=%0d expected=less", cyc);
    summary();
  end

  initial begin
    logic [31:0] dir [0:27];
    dir = '{32'h3F800000, 32'hBF800000, 32'h40200000, 32'hC0200000, 32'h3FC00000, 32'hBFC00000,
            32'h3F000000, 32'hBF000000, 32'h40600000, 32'h4EFFFFFF, 32'h4F000000, 32'hCF000000,
            32'hCF000001, 32'hCEFFFFFF, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h7F800001,
            32'hFFC00000, 32'h00000001, 32'h80000001, 32'h00000000, 32'h80000000, 32'h007FFFFF,
            32'h5F000000, 32'hDF000000, 32'h4B800001, 32'h3F7FFFFF};
    repeat (4) @(negedge clk);
    // R10: outputs quiet under reset
    chk(out_valid == 0 && out_int == 0 && out_nv == 0 && out_nx == 0 && out_rm_err == 0,
        "R10", "reset outputs", out_int, 32'd0);
    rst_n = 1'b1;
    idle(2);
    for (int i = 0; i < 28; i++)
      for (int r = 0; r < 8; r++) begin
        drive(dir[i], 3'(r));
        if (r == 3) idle(1);
      end
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x; logic [2:0] rm;
      x = $urandom;
      if (i % 2 == 0) x[30:23] = 8'(110 + ($urandom % 56));
      rm = (i % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      drive(x, rm);
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    summary();
  end
endmodule